// File: doc/BRIEF.md
# Multiplexed Bidirectional GPIO Port

This block is an 8-bit general-purpose I/O port that sits between a register bus and a row of pads. Each pin has a direction bit and an output latch bit. A single control bit turns on the weak pull-ups of every pin. Software programs the port through four register addresses. Pin levels come back through a two-flop synchronizer.

Two peripherals can take pins away from the port latch. When the streaming parallel port is enabled, it owns every pin: it supplies the drive value and the output enable, and it selects the alternate input buffer. A three-channel PWM can own the upper three pins, depending on its output mode. The PWM has the highest priority, the streaming port comes next, and the latch comes last. A pull-up is on only when software has enabled pull-ups and the pin is a plain GPIO input. A shutdown input releases the PWM-owned pins to high impedance.

Top module: `gpio_mux_port`

## Requirements
- R1: While reset is held and after it is released, every direction bit reads 1, the latch reads 0 and the pull-up enable reads 0. With no peripheral active, `pad_oe` and `pad_pu` are then all 0.
- R2: On a pin owned by GPIO, a direction bit of 0 sets `pad_oe` to 1 and puts the latch bit on `pad_out`. A direction bit of 1 clears `pad_oe`.
- R3: A write to address 0 (pin) or address 1 (latch) loads `reg_wdata` into the latch from the next clock edge on. A read of address 1 returns the latch, never the pin level.
- R4: A read of address 0, and the `stream_din` output, return the `pad_in` value sampled two rising clock edges earlier.
- R5: Bit 0 of address 3 is the global pull-up enable. When it is 1, `pad_pu` is 1 on every GPIO pin whose direction bit is 1.
- R6: `pad_pu` is 0 on any pin that is being driven (`pad_oe` = 1) or that a peripheral owns, whatever the value of the pull-up enable.
- R7: While `stream_en` is 1, every pin that the PWM does not own takes `pad_out` from `stream_dout`, takes `pad_oe` from `stream_oe`, and has `pad_ttl` set to 1. The direction register and the latch have no effect on that pin.
- R8: `pwm_mode` decides which pins the PWM owns: 0 owns none, 1 owns pin 5 only, and 2 or 3 owns pins 5 to 7. On an owned pin, `pad_out` is `pwm_dout[pin-5]`, and this takes priority over both the streaming port and the latch.
- R9: While `pwm_shutdown` is 1, `pad_oe` is 0 on the pins the PWM owns. Pins the PWM does not own are unaffected.
- R10: Reads are combinational in the same cycle. Address 2 returns the direction register and address 3 returns the pull-up enable in bit 0, with zeros above it. A write to address 2 loads the direction register and a write to address 3 loads the pull-up enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 pin, 1 latch, 2 direction, 3 control) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| stream_en | input | 1 | Streaming port takes ownership of the pins |
| stream_dout | input | 8 | Streaming port drive values |
| stream_oe | input | 8 | Streaming port per-pin output enables |
| stream_din | output | 8 | Synchronized pin levels sent to the streaming port |
| pwm_mode | input | 2 | PWM output mode selecting the owned pins |
| pwm_dout | input | 3 | PWM channel outputs for pins 5, 6 and 7 |
| pwm_shutdown | input | 1 | Releases the PWM-owned pins to high impedance |
| pad_in | input | 8 | Raw pad levels |
| pad_out | output | 8 | Pad drive values |
| pad_oe | output | 8 | Pad output enables |
| pad_pu | output | 8 | Pad weak pull-up enables |
| pad_ttl | output | 8 | Selects the alternate input buffer for each pad |

## Verification
The pad controls (`pad_out`, `pad_oe`, `pad_pu`, `pad_ttl`) and the read data are combinational in the same cycle as their inputs. The bench checks them 1 ns after it drives inputs at the falling edge. A register write appears on the pads and on the read-back only after the next rising edge, so the bench's model applies the write at that edge. The pin read and `stream_din` lag `pad_in` by two rising edges, and the model keeps a two-entry history that is shifted at each edge to match. The assertions check the same latencies with `$past` after a count of edges since reset release.

// File: rtl/gpio_mux_pkg.sv
// Shared types for the multiplexed GPIO port.
// Assumes a 2-bit register address and a 2-bit PWM mode field.
package gpio_mux_pkg;

    typedef enum logic [1:0] {
        ADDR_PIN = 2'd0,
        ADDR_LAT = 2'd1,
        ADDR_DIR = 2'd2,
        ADDR_CTL = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        PWM_SINGLE = 2'd0,
        PWM_DUAL   = 2'd1,
        PWM_QUAD   = 2'd2,
        PWM_QUAD_B = 2'd3
    } pwm_mode_e;

endpackage

// File: rtl/gpio_sync.sv
// Multi-stage synchronizer for the raw pad levels.
// Assumes pad_in is asynchronous to clk. All stages clear on reset.
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    // first stage captures the raw pad value
    always_ff @(posedge clk) begin
        if (!rst_n) stage[0] <= '0;
        else        stage[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // each further stage re-registers the stage before it
        always_ff @(posedge clk) begin
            if (!rst_n) stage[s] <= '0;
            else        stage[s] <= stage[s-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
// Register file of the port: output latch, direction, pull-up enable.
// Assumes single-cycle writes and a combinational read mux.
module gpio_regs #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_sync,
    output logic [W-1:0] rdata,
    output logic [W-1:0] lat_q,
    output logic [W-1:0] dir_q,
    output logic         pu_en_q
);
    import gpio_mux_pkg::*;

    reg_addr_e a;
    assign a = reg_addr_e'(addr);

    // output latch: loaded by a write to the pin or the latch address
    always_ff @(posedge clk) begin
        if (!rst_n)                                   lat_q <= '0;
        else if (wr && (a == ADDR_PIN || a == ADDR_LAT)) lat_q <= wdata;
    end

    // direction register: all pins are inputs after reset
    always_ff @(posedge clk) begin
        if (!rst_n)                      dir_q <= '1;
        else if (wr && a == ADDR_DIR)    dir_q <= wdata;
    end

    // global pull-up enable in bit 0 of the control address
    always_ff @(posedge clk) begin
        if (!rst_n)                      pu_en_q <= 1'b0;
        else if (wr && a == ADDR_CTL)    pu_en_q <= wdata[0];
    end

    // read mux: the pin address returns synchronized levels
    always_comb begin
        unique case (a)
            ADDR_PIN: rdata = pin_sync;
            ADDR_LAT: rdata = lat_q;
            ADDR_DIR: rdata = dir_q;
            default:  rdata = {{(W-1){1'b0}}, pu_en_q};
        endcase
    end
endmodule

// File: rtl/gpio_pwm_claim.sv
// Decodes the PWM output mode into a per-pin ownership mask.
// Assumes the PWM channels sit on CH consecutive pins starting at BASE.
module gpio_pwm_claim #(
    parameter int W    = 8,
    parameter int BASE = 5,
    parameter int CH   = 3
) (
    input  logic [1:0]   mode,
    output logic [W-1:0] claim
);
    import gpio_mux_pkg::*;

    // single frees all, dual takes the first channel, quad takes all
    always_comb begin
        claim = '0;
        unique case (pwm_mode_e'(mode))
            PWM_DUAL: claim[BASE] = 1'b1;
            PWM_QUAD, PWM_QUAD_B: begin
                for (int k = 0; k < CH; k++) claim[BASE+k] = 1'b1;
            end
            default: claim = '0;
        endcase
    end
endmodule

// File: rtl/gpio_pin_mux.sv
// Per-pin priority mux: PWM over streaming port over GPIO latch.
// Assumes pull-ups are only wanted on plain GPIO inputs.
module gpio_pin_mux #(
    parameter int W    = 8,
    parameter int BASE = 5,
    parameter int CH   = 3
) (
    input  logic [W-1:0]  lat,
    input  logic [W-1:0]  dir,
    input  logic          pu_en,
    input  logic          stream_en,
    input  logic [W-1:0]  stream_dout,
    input  logic [W-1:0]  stream_oe,
    input  logic [W-1:0]  claim,
    input  logic [CH-1:0] pwm_dout,
    input  logic          pwm_shutdown,
    output logic [W-1:0]  pad_out,
    output logic [W-1:0]  pad_oe,
    output logic [W-1:0]  pad_pu,
    output logic [W-1:0]  pad_ttl
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        logic pwm_bit;
        if (i >= BASE && i < BASE + CH) begin : g_pwm
            assign pwm_bit = pwm_dout[i-BASE];
        end else begin : g_nopwm
            assign pwm_bit = 1'b0;
        end

        // pick the owner of this pin and its drive/enable
        always_comb begin
            if (claim[i]) begin
                pad_out[i] = pwm_bit;
                pad_oe[i]  = ~pwm_shutdown;
            end else if (stream_en) begin
                pad_out[i] = stream_dout[i];
                pad_oe[i]  = stream_oe[i];
            end else begin
                pad_out[i] = lat[i];
                pad_oe[i]  = ~dir[i];
            end
        end

        // pull-up only on GPIO-owned inputs; alternate buffer for stream pins
        always_comb begin
            pad_pu[i]  = pu_en & dir[i] & ~claim[i] & ~stream_en;
            pad_ttl[i] = stream_en & ~claim[i];
        end
    end
endmodule

// File: rtl/gpio_mux_port.sv
// Top of the multiplexed GPIO port: registers, synchronizer, PWM decode, pin mux.
// Assumes a synchronous active-low reset and pads driven outside this block.
module gpio_mux_port #(
    parameter int WIDTH       = 8,
    parameter int PWM_BASE    = 5,
    parameter int PWM_CH      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [WIDTH-1:0]  reg_wdata,
    output logic [WIDTH-1:0]  reg_rdata,
    input  logic              stream_en,
    input  logic [WIDTH-1:0]  stream_dout,
    input  logic [WIDTH-1:0]  stream_oe,
    output logic [WIDTH-1:0]  stream_din,
    input  logic [1:0]        pwm_mode,
    input  logic [PWM_CH-1:0] pwm_dout,
    input  logic              pwm_shutdown,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pad_pu,
    output logic [WIDTH-1:0]  pad_ttl
);
    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] lat_q;
    logic [WIDTH-1:0] dir_q;
    logic             pu_en_q;
    logic [WIDTH-1:0] pwm_claim;

    gpio_sync #(.W(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pin_sync)
    );

    gpio_regs #(.W(WIDTH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .pin_sync (pin_sync),
        .rdata    (reg_rdata),
        .lat_q    (lat_q),
        .dir_q    (dir_q),
        .pu_en_q  (pu_en_q)
    );

    gpio_pwm_claim #(.W(WIDTH), .BASE(PWM_BASE), .CH(PWM_CH)) u_claim (
        .mode  (pwm_mode),
        .claim (pwm_claim)
    );

    gpio_pin_mux #(.W(WIDTH), .BASE(PWM_BASE), .CH(PWM_CH)) u_mux (
        .lat          (lat_q),
        .dir          (dir_q),
        .pu_en        (pu_en_q),
        .stream_en    (stream_en),
        .stream_dout  (stream_dout),
        .stream_oe    (stream_oe),
        .claim        (pwm_claim),
        .pwm_dout     (pwm_dout),
        .pwm_shutdown (pwm_shutdown),
        .pad_out      (pad_out),
        .pad_oe       (pad_oe),
        .pad_pu       (pad_pu),
        .pad_ttl      (pad_ttl)
    );

    assign stream_din = pin_sync;
endmodule

// File: rtl/gpio_mux_port_chk.sv
// Assertion checker for gpio_mux_port, attached with bind.
// Assumes the default pin assignment of the PWM channels (pins 5 to 7).
module gpio_mux_port_chk #(
    parameter int WIDTH  = 8,
    parameter int PWM_CH = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [1:0]        reg_addr,
    input logic [WIDTH-1:0]  reg_wdata,
    input logic [WIDTH-1:0]  reg_rdata,
    input logic [WIDTH-1:0]  stream_din,
    input logic [1:0]        pwm_mode,
    input logic [PWM_CH-1:0] pwm_dout,
    input logic              pwm_shutdown,
    input logic [WIDTH-1:0]  pad_in,
    input logic [WIDTH-1:0]  pad_out,
    input logic [WIDTH-1:0]  pad_oe,
    input logic [WIDTH-1:0]  pad_pu,
    input logic [WIDTH-1:0]  lat_q
);
    logic [1:0] age;

    // counts rising edges since reset release, saturating at 3
    always_ff @(posedge clk) begin
        if (!rst_n)         age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    AST_PU_OFF_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_pu == '0)); // R1

    AST_PU_NOT_WHEN_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_oe) == '0); // R6

    AST_LATCH_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr <= 2'd1) |=> (lat_q == $past(reg_wdata))); // R3

    AST_PIN_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2 && reg_addr == 2'd0) |-> (reg_rdata == $past(pad_in, 2))); // R4

    AST_STREAM_DIN_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2) |-> (stream_din == $past(pad_in, 2))); // R4

    AST_PWM_QUAD_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_mode[1]) |-> (pad_out[7:5] == pwm_dout)); // R8

    AST_SHUTDOWN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_shutdown && pwm_mode != 2'd0) |-> (pad_oe[5] == 1'b0)); // R9
endmodule

bind gpio_mux_port gpio_mux_port_chk #(.WIDTH(WIDTH), .PWM_CH(PWM_CH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .stream_din   (stream_din),
    .pwm_mode     (pwm_mode),
    .pwm_dout     (pwm_dout),
    .pwm_shutdown (pwm_shutdown),
    .pad_in       (pad_in),
    .pad_out      (pad_out),
    .pad_oe       (pad_oe),
    .pad_pu       (pad_pu),
    .lat_q        (lat_q)
);

// File: tb/tb_gpio_mux_port.sv
// Self-checking bench: directed corner cases, then seeded random traffic against a model.
module tb_gpio_mux_port;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       reg_wr;
    logic [1:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       stream_en;
    logic [7:0] stream_dout, stream_oe, stream_din;
    logic [1:0] pwm_mode;
    logic [2:0] pwm_dout;
    logic       pwm_shutdown;
    logic [7:0] pad_in, pad_out, pad_oe, pad_pu, pad_ttl;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // model state
    logic [7:0] m_lat, m_dir, m_p1, m_p2;
    logic       m_pu;

    always #5 clk = ~clk;

    gpio_mux_port dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stream_en(stream_en),
        .stream_dout(stream_dout), .stream_oe(stream_oe), .stream_din(stream_din),
        .pwm_mode(pwm_mode), .pwm_dout(pwm_dout), .pwm_shutdown(pwm_shutdown),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
        .pad_ttl(pad_ttl)
    );

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] claim_of(input logic [1:0] mode);
        case (mode)
            2'd1:    return 8'h20;
            2'd2,
            2'd3:    return 8'hE0;
            default: return 8'h00;
        endcase
    endfunction

    // one rising edge: apply the model updates, then return at the falling edge
    task automatic tick();
        @(posedge clk);
        if (!rst_n) begin
            m_lat = 8'h00; m_dir = 8'hFF; m_pu = 1'b0; m_p1 = 8'h00; m_p2 = 8'h00;
        end else begin
            m_p2 = m_p1; m_p1 = pad_in;
            if (reg_wr) begin
                case (reg_addr)
                    2'd0, 2'd1: m_lat = reg_wdata;
                    2'd2:       m_dir = reg_wdata;
                    default:    m_pu  = reg_wdata[0];
                endcase
            end
        end
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    // compare every output against expectations built from the requirements
    task automatic check_all();
        logic [7:0] cl, e_out, e_oe, e_pu, e_ttl, e_rd;
        #1;
        cl = claim_of(pwm_mode);
        for (int i = 0; i < 8; i++) begin
            if (cl[i]) begin
                e_out[i] = pwm_dout[i-5]; e_oe[i] = ~pwm_shutdown;
            end else if (stream_en) begin
                e_out[i] = stream_dout[i]; e_oe[i] = stream_oe[i];
            end else begin
                e_out[i] = m_lat[i]; e_oe[i] = ~m_dir[i];
            end
            e_pu[i]  = m_pu & m_dir[i] & ~cl[i] & ~stream_en;
            e_ttl[i] = stream_en & ~cl[i];
        end
        case (reg_addr)
            2'd0:    e_rd = m_p2;
            2'd1:    e_rd = m_lat;
            2'd2:    e_rd = m_dir;
            default: e_rd = {7'b0, m_pu};
        endcase
        chk("R2,R7,R8", "pad_out", pad_out, e_out);
        chk("R2,R7,R9", "pad_oe", pad_oe, e_oe);
        chk("R5,R6", "pad_pu", pad_pu, e_pu);
        chk("R7", "pad_ttl", pad_ttl, e_ttl);
        chk("R3,R4,R10", "reg_rdata", reg_rdata, e_rd);
        chk("R4", "stream_din", stream_din, m_p2);
    endtask

    // watchdog: a hung run counts as a failure and still reports
    initial begin
        #2000000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 2'd2; reg_wdata = 8'h00;
        stream_en = 1'b0; stream_dout = 8'h00; stream_oe = 8'h00;
        pwm_mode = 2'd0; pwm_dout = 3'b000; pwm_shutdown = 1'b0; pad_in = 8'h00;
        m_lat = 8'h00; m_dir = 8'hFF; m_pu = 1'b0; m_p1 = 8'h00; m_p2 = 8'h00;
        @(negedge clk);
        tick(); tick();
        // R1: reset state during reset and after release
        #1;
        chk("R1", "oe in reset", pad_oe, 8'h00);
        chk("R1", "pu in reset", pad_pu, 8'h00);
        rst_n = 1'b1;
        tick();
        chk("R1", "dir after reset", reg_rdata, 8'hFF);
        reg_addr = 2'd1; #1;
        chk("R1", "latch after reset", reg_rdata, 8'h00);
        check_all();

        // R2, R3: direction and latch write via the pin address
        wr(2'd2, 8'hCF);
        wr(2'd0, 8'hA5);
        reg_addr = 2'd1; pad_in = 8'h00; #1;
        chk("R3", "latch read not pin", reg_rdata, 8'hA5);
        chk("R2", "oe from dir", pad_oe, 8'h30);
        chk("R2", "driven bits", pad_out & pad_oe, 8'h20);
        check_all();

        // R5, R6: pull-ups only on GPIO inputs
        wr(2'd3, 8'h01);
        reg_addr = 2'd3; #1;
        chk("R10", "ctl read", reg_rdata, 8'h01);
        chk("R5", "pull-ups on inputs", pad_pu, 8'hCF);
        check_all();

        // R7: streaming port owns all pins
        stream_en = 1'b1; stream_dout = 8'h3C; stream_oe = 8'h0F; #1;
        chk("R7", "stream out", pad_out, 8'h3C);
        chk("R7", "stream oe", pad_oe, 8'h0F);
        chk("R7", "ttl select", pad_ttl, 8'hFF);
        chk("R6", "pu off for stream", pad_pu, 8'h00);

        // R8: dual then quad over the streaming port
        pwm_mode = 2'd1; pwm_dout = 3'b101; #1;
        chk("R8", "dual out", pad_out, 8'h3C);
        chk("R8", "dual ttl", pad_ttl, 8'hDF);
        chk("R8", "dual oe", pad_oe, 8'h2F);
        pwm_mode = 2'd2; #1;
        chk("R8", "quad out", pad_out, 8'hBC);
        // R9: shutdown releases the PWM pins only
        pwm_shutdown = 1'b1; #1;
        chk("R9", "shutdown oe", pad_oe, 8'h0F);
        stream_en = 1'b0; pwm_mode = 2'd0; pwm_shutdown = 1'b0;

        // R4: two-edge latency of the pin read
        reg_addr = 2'd0; pad_in = 8'h5A;
        tick();
        pad_in = 8'h00; #1;
        chk("R4", "one edge old", reg_rdata, 8'h00);
        tick(); #1;
        chk("R4", "two edges new", reg_rdata, 8'h5A);
        tick();

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            reg_wr       = ($urandom % 4) == 0;
            reg_addr     = 2'($urandom);
            reg_wdata    = 8'($urandom);
            stream_en    = ($urandom % 4) == 0;
            stream_dout  = 8'($urandom);
            stream_oe    = 8'($urandom);
            pwm_mode     = 2'($urandom);
            pwm_dout     = 3'($urandom);
            pwm_shutdown = ($urandom % 5) == 0;
            pad_in       = 8'($urandom);
            check_all();
            tick();
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule